// File: doc/BRIEF.md
# Single-Lane Byte Transfer Sequencer

This block moves a 16-bit or 32-bit register value between a core and an 8-bit peripheral that sits on one byte lane of a 16-bit bus. Because such a device answers only at every other byte address, the block splits the value into bytes and runs one bus cycle per byte. The address steps by two after each byte, so every byte lands on the same lane.

A transfer starts with a one-cycle start strobe. The start carries a direction (write to the device or read from it), a size (word or long), a base address and a signed 16-bit displacement. The first byte address is the base plus the sign-extended displacement. Bytes move most significant first. In a read, the returned bytes are packed into a copy of the current destination value, and for a word read the upper half of that value is kept. The bus handshake is a plain strobe/acknowledge pair, and any number of wait states may be added. A single-cycle done pulse marks the end of the transfer.

Top module: `lane_xfer_seq`

## Requirements
- R1: A start seen while idle is accepted at that clock edge. From the next cycle `busy` and `bus_stb` are high, and `bus_we` is 1 for a write (`rd_dir`=0) or 0 for a read (`rd_dir`=1).
- R2: The first bus address is `base_addr` plus `disp`. Each later byte uses the previous address plus 2.
- R3: A word transfer (`size_long`=0) makes exactly 2 bus cycles and a long transfer (`size_long`=1) makes exactly 4.
- R4: A write sends the most significant byte of the selected size first: bits [31:24], [23:16], [15:8], [7:0] for a long, and bits [15:8], [7:0] for a word.
- R5: Strobe, address, write data and direction stay unchanged until `bus_ack` is sampled high at a clock edge.
- R6: A read places the first returned byte in the most significant byte of the selected size, followed by the later bytes in order. For a word read, `rd_result[31:16]` equals `cur_val[31:16]` as sampled at start.
- R7: `done` is high for exactly one cycle, in the cycle after the edge that samples the last acknowledge. During that cycle `busy` and `bus_stb` are low.
- R8: A start raised while busy is ignored. The running transfer keeps its addresses and data, and no extra bus cycle follows it.
- R9: After reset `bus_stb`, `busy` and `done` are low.
- R10: A negative displacement is sign-extended, so the first address can lie below the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| rd_dir | input | 1 | 1 = read from the device, 0 = write to it |
| size_long | input | 1 | 1 = four bytes, 0 = two bytes |
| base_addr | input | AW | Base address |
| disp | input | DISP_W | Signed displacement |
| wr_val | input | 32 | Value to write |
| cur_val | input | 32 | Current destination value for reads |
| bus_addr | output | AW | Byte address of the current bus cycle |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte |
| bus_stb | output | 1 | Bus cycle request |
| bus_we | output | 1 | Write enable |
| bus_ack | input | 1 | Bus cycle complete |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_result | output | 32 | Assembled read value, valid with `done` |

## Verification
A byte counter that has drifted shows up at once: the transfer ends early, or an extra strobe appears after the expected number of bytes, and the cycle count is checked at the done pulse. A bad address register is seen in the first bus cycle that uses it, either at the first address or at the first step of 2. A shift register that selects or assembles the wrong byte shows up in the first write byte compared, or in the read value presented with `done`. The bench uses several wait-state settings so that any slip in holding or advancing during a stall appears in the cycle where it happens.

// File: rtl/lxs_pkg.sv
package lxs_pkg;
    localparam int VAL_W  = 32;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 3;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_RUN  = 1'b1
    } xs_state_e;

    typedef struct packed {
        logic rd;
        logic lng;
    } xfer_mode_t;

    function automatic logic [CNT_W-1:0] byte_total(input logic lng);
        return lng ? CNT_W'(4) : CNT_W'(2);
    endfunction
endpackage

// File: rtl/lxs_ctrl.sv
module lxs_ctrl
    import lxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  xfer_mode_t mode_in,
    input  logic       ack,
    output logic       load,
    output logic       adv,
    output logic       busy,
    output logic       done,
    output xfer_mode_t mode_q
);
    xs_state_e        state_q;
    logic [CNT_W-1:0] left_q;
    logic             last;

    assign busy = (state_q == XS_RUN);
    assign load = start && (state_q == XS_IDLE);
    assign adv  = busy && ack;
    assign last = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            left_q  <= '0;
            done    <= 1'b0;
            mode_q  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state_q <= XS_RUN;
                left_q  <= byte_total(mode_in.lng);
                mode_q  <= mode_in;
            end else if (adv) begin
                left_q <= left_q - CNT_W'(1);
                if (last) begin
                    state_q <= XS_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lxs_addr_gen.sv
module lxs_addr_gen #(
    parameter int AW     = 24,
    parameter int DISP_W = 16,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [AW-1:0]     base,
    input  logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     addr_q
);
    localparam int EXT_W = AW - DISP_W;

    logic [AW-1:0] disp_ext;
    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base + disp_ext;
        end else if (adv) begin
            addr_q <= addr_q + AW'(STEP);
        end
    end
endmodule

// File: rtl/lxs_byte_shifter.sv
module lxs_byte_shifter
    import lxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  xfer_mode_t        mode_in,
    input  xfer_mode_t        mode_q,
    input  logic [VAL_W-1:0]  wr_val,
    input  logic [VAL_W-1:0]  cur_val,
    input  logic [BYTE_W-1:0] rbyte,
    output logic [BYTE_W-1:0] wbyte,
    output logic [VAL_W-1:0]  value_q
);
    localparam int HALF_W = VAL_W / 2;

    assign wbyte = mode_q.lng ? value_q[VAL_W-1 -: BYTE_W]
                              : value_q[HALF_W-1 -: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (load) begin
            value_q <= mode_in.rd ? cur_val : wr_val;
        end else if (adv) begin
            if (mode_q.lng)
                value_q <= {value_q[VAL_W-BYTE_W-1:0], rbyte};
            else
                value_q <= {value_q[VAL_W-1:HALF_W],
                            value_q[HALF_W-BYTE_W-1:0], rbyte};
        end
    end
endmodule

// File: rtl/lane_xfer_seq.sv
module lane_xfer_seq
    import lxs_pkg::*;
#(
    parameter int AW     = 24,
    parameter int DISP_W = 16,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_dir,
    input  logic              size_long,
    input  logic [AW-1:0]     base_addr,
    input  logic [DISP_W-1:0] disp,
    input  logic [VAL_W-1:0]  wr_val,
    input  logic [VAL_W-1:0]  cur_val,
    output logic [AW-1:0]     bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_stb,
    output logic              bus_we,
    input  logic              bus_ack,
    output logic              busy,
    output logic              done,
    output logic [VAL_W-1:0]  rd_result
);
    xfer_mode_t mode_in, mode_q;
    logic       load, adv;

    assign mode_in = '{rd: rd_dir, lng: size_long};

    lxs_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode_in(mode_in), .ack(bus_ack),
        .load(load), .adv(adv), .busy(busy), .done(done), .mode_q(mode_q)
    );

    lxs_addr_gen #(.AW(AW), .DISP_W(DISP_W), .STEP(STEP)) u_addr (
        .clk(clk), .rst(rst), .load(load), .adv(adv),
        .base(base_addr), .disp(disp), .addr_q(bus_addr)
    );

    lxs_byte_shifter u_shift (
        .clk(clk), .rst(rst), .load(load), .adv(adv),
        .mode_in(mode_in), .mode_q(mode_q),
        .wr_val(wr_val), .cur_val(cur_val), .rbyte(bus_rdata),
        .wbyte(bus_wdata), .value_q(rd_result)
    );

    assign bus_stb = busy;
    assign bus_we  = busy && !mode_q.rd;
endmodule

// File: rtl/lxs_checker.sv
module lxs_checker #(
    parameter int AW   = 24,
    parameter int STEP = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          size_long,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_stb,
    input logic          bus_we,
    input logic          bus_ack,
    input logic          busy,
    input logic          done
);
    logic [2:0] acks_q, want_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acks_q <= '0;
            want_q <= '0;
        end else if (start && !busy) begin
            acks_q <= '0;
            want_q <= size_long ? 3'd4 : 3'd2;
        end else if (bus_stb && bus_ack) begin
            acks_q <= acks_q + 3'd1;
        end
    end

    assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (bus_stb && busy));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_ack) |=> (!bus_stb || bus_addr == $past(bus_addr) + AW'(STEP)));

    assert_count_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (acks_q == want_q));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_ack) |=> (bus_stb && $stable(bus_addr)
                                   && $stable(bus_wdata) && $stable(bus_we)));

    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !bus_stb));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !bus_ack) |=> (busy && $stable(bus_addr)));
endmodule

bind lane_xfer_seq lxs_checker #(.AW(AW), .STEP(STEP)) u_chk (
    .clk(clk), .rst(rst), .start(start), .size_long(size_long),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_ack(bus_ack), .busy(busy), .done(done)
);

// File: tb/sim_lane_xfer_seq.sv
module sim_lane_xfer_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, rd_dir = 1'b0, size_long = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [15:0]   disp = '0;
    logic [31:0]   wr_val = '0, cur_val = '0;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata = '0;
    logic          bus_stb, bus_we, busy, done;
    logic          bus_ack = 1'b0;
    logic [31:0]   rd_result;

    int checks = 0;
    int fails  = 0;
    int wait_n = 0;
    int wcnt   = 0;

    logic [AW-1:0] exp_addr[$];
    logic          exp_we[$];
    logic [7:0]    exp_wd[$];
    logic [7:0]    rd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_xfer_seq #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .start(start), .rd_dir(rd_dir), .size_long(size_long),
        .base_addr(base_addr), .disp(disp), .wr_val(wr_val), .cur_val(cur_val),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_ack(bus_ack),
        .busy(busy), .done(done), .rd_result(rd_result)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor / responder: compares each bus cycle with the scoreboard front
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (bus_stb) begin
            if (exp_addr.size() == 0) begin
                chk(1'b0, "R3 unexpected extra bus cycle", 32'(bus_addr), 32'hx);
                bus_ack = 1'b1;
            end else begin
                chk(bus_addr == exp_addr[0], "R2 byte address (R5 hold)",
                    32'(bus_addr), 32'(exp_addr[0]));
                chk(bus_we == exp_we[0], "R1 direction", 32'(bus_we), 32'(exp_we[0]));
                if (exp_we[0])
                    chk(bus_wdata == exp_wd[0], "R4 write byte order",
                        32'(bus_wdata), 32'(exp_wd[0]));
                if (wcnt >= wait_n) begin
                    bus_ack = 1'b1;
                    if (!exp_we[0] && rd_q.size() > 0) bus_rdata = rd_q.pop_front();
                    void'(exp_addr.pop_front());
                    void'(exp_we.pop_front());
                    void'(exp_wd.pop_front());
                    wcnt = 0;
                end else begin
                    bus_ack = 1'b0;
                    wcnt++;
                end
            end
        end else begin
            bus_ack = 1'b0;
            wcnt = 0;
        end
    end

    // driver: pushes expected bus items, then runs one transfer
    task automatic xfer(input bit rd, input bit lng, input logic [AW-1:0] base,
                        input logic [15:0] d, input logic [31:0] val,
                        input logic [31:0] cval, input logic [31:0] rbytes,
                        input int waits, input int poke_at, input string first_tag);
        int n = lng ? 4 : 2;
        logic [AW-1:0] a0 = base + {{(AW-16){d[15]}}, d};
        logic [31:0] exp_res;
        int cyc = 0;
        for (int i = 0; i < n; i++) begin
            exp_addr.push_back(a0 + AW'(2 * i));
            exp_we.push_back(!rd);
            exp_wd.push_back(val[8*(n-1-i) +: 8]);
            if (rd) rd_q.push_back(rbytes[8*(n-1-i) +: 8]);
        end
        exp_res = lng ? rbytes : {cval[31:16], rbytes[15:0]};
        wait_n = waits;
        rd_dir = rd; size_long = lng; base_addr = base; disp = d;
        wr_val = val; cur_val = cval; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(bus_stb && busy, "R1 strobe and busy after start", 32'({bus_stb, busy}), 32'h3);
        chk(bus_addr == a0, first_tag, 32'(bus_addr), 32'(a0));
        while (!done && cyc < 200) begin
            if (cyc == poke_at) begin
                start = 1'b1; rd_dir = ~rd; size_long = ~lng;
                base_addr = base + AW'(24'h40); disp = 16'h0010;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done, "R7 done reached", 32'(done), 32'h1);
        chk(!busy && !bus_stb, "R7 idle during done", 32'({busy, bus_stb}), 32'h0);
        chk(exp_addr.size() == 0, "R3 byte count", 32'(exp_addr.size()), 32'h0);
        if (rd) chk(rd_result == exp_res, "R6 read assembly", rd_result, exp_res);
        @(negedge clk);
        chk(!done, "R7 done width", 32'(done), 32'h0);
        chk(!bus_stb, poke_at >= 0 ? "R8 no restart after ignored start" : "R3 no trailing cycle",
            32'(bus_stb), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_stb && !busy && !done, "R9 reset outputs",
            32'({bus_stb, busy, done}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_stb && !busy && !done, "R9 idle after reset",
            32'({bus_stb, busy, done}), 32'h0);
        xfer(0, 1, 24'h001000, 16'h0000, 32'h1234_5678, 32'h0, 32'h0, 0, -1, "R2 first address long");
        xfer(0, 0, 24'h002001, 16'h0005, 32'hDEAD_BEEF, 32'h0, 32'h0, 2, -1, "R2 first address word");
        xfer(1, 1, 24'h000100, 16'hFFFD, 32'h0, 32'h0, 32'hA1B2_C3D4, 1, -1, "R10 negative displacement");
        xfer(1, 0, 24'h004000, 16'h0002, 32'h0, 32'hAABB_CCDD, 32'h0000_5A6B, 0, -1, "R2 first address word read");
        xfer(0, 1, 24'h008000, 16'h8000, 32'h0F1E_2D3C, 32'h0, 32'h0, 3, 2, "R10 most negative displacement");
        xfer(1, 1, 24'h00A000, 16'h0006, 32'h0, 32'h1111_1111, 32'h9988_7766, 2, 5, "R8 first address under poke");
        xfer(0, 0, 24'hFFFFFE, 16'h0000, 32'h0000_C35A, 32'h0, 32'h0, 0, -1, "R2 first address at wrap");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule